// File: doc/BRIEF.md
# External Bus Cycle Controller

This block runs the external bus cycles of a processor core over a 16-bit data bus. The core presents one request at a time with an address, an access size, a direction, a memory/I-O flag and a burst flag. The controller then walks a named-state machine: idle, hold, an address state, and one of three data-state paths. A byte or halfword single uses one data state. A word single is split into two halfword accesses. A burst moves four words as eight halfword data states after a single address state.

The data states are stretched by a READY input. Read halfwords are put back together into 32-bit words for the core. A bus hold request is honoured only while idle or at the moment an access completes. Burst requests that point at I/O space or at an address that is not on a 16-byte boundary are refused with a one-cycle error pulse, and no bus activity follows.

Top module: `xbus_seq`

## Requirements
- R1: After reset, and while no request arrives, `bus_cs`, `bus_strb`, `bus_oe`, `hold_ack`, `done`, `err` and `rd_valid` are all low.
- R2: When `hold_req` is high on an edge while idle, `hold_ack` is high from the next cycle and the bus stays quiet. A request offered on that same edge is dropped. When `hold_req` falls, the controller returns to idle and accepts later requests normally.
- R3: `hold_req` is sampled during an access only on the edge that completes it. An access in progress always runs to completion. If `hold_req` is high on that final edge, the hold state follows at once without passing through idle.
- R4: When `req_valid` is sampled while idle with no hold, the next cycle is an address state. In that state `bus_strb` and `bus_cs` are high and `bus_addr` is the request address. The address state lasts exactly one cycle. A request completes on the first edge of its data state at which `bus_ready` is high, and `done` pulses in the following cycle.
- R5: On a single write, `bus_oe` is high and `bus_wdata` carries the data from the address state through the data states. On a burst write, `bus_oe` is low in the address state and high in each data state.
- R6: While `bus_ready` is low at the end of a data state, that state repeats with `bus_addr`, `bus_cs` and `bus_wdata` unchanged.
- R7: Size codes are 2'b00 for a byte, 2'b01 for a halfword and 2'b10 for a word. `bus_be[0]` enables bits 7:0 and `bus_be[1]` enables bits 15:8.
   - A byte uses lane `bus_be = 2'b01` at an even address and `2'b10` at an odd address. A written byte appears on both lanes. A read byte comes from the lane chosen by address bit 0 and is zero-extended.
   - A halfword uses `bus_be = 2'b11` and is read zero-extended.
- R8: A word single performs two accesses, each with its own address state. The first is at the request address and the second at the address plus 2. Read data is returned as `{second halfword, first halfword}`. `rd_valid` and `done` pulse one cycle after the final READY.
- R9: A burst has one address state followed by eight halfword data states. The address rises by 2 after each accepted halfword, and `bus_be = 2'b11`. On a burst read, `rd_valid` pulses once per assembled word, four times in all. The data written in a burst is `req_wdata` taken halfword by halfword from bit 0 upward.
- R10: A burst request with `req_io` high, or with any of address bits 3:0 set, makes `err` pulse for one cycle. No bus cycle is started for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered (sampled while idle) |
| req_addr | input | AW | Request byte address |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word |
| req_write | input | 1 | 1 write, 0 read |
| req_io | input | 1 | 1 I/O space, 0 memory space |
| req_burst | input | 1 | Four-word burst |
| req_wdata | input | 32*BURST_WORDS | Write data, halfword 0 in the low bits |
| rd_valid | output | 1 | Assembled read word valid |
| rd_data | output | 32 | Read word |
| done | output | 1 | Request completed |
| err | output | 1 | Burst request refused |
| bus_strb | output | 1 | Cycle-start strobe (address state) |
| bus_cs | output | 1 | Chip select during an access |
| bus_io | output | 1 | Space of the current access |
| bus_wr | output | 1 | Direction of the current access |
| bus_addr | output | AW | Current halfword address |
| bus_be | output | 2 | Byte lane enables |
| bus_oe | output | 1 | Write data drive enable |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| bus_ready | input | 1 | Data state may finish |
| hold_req | input | 1 | External hold request |
| hold_ack | output | 1 | Bus released for hold |

## Verification
The bench tries each access path under two READY patterns. With READY always high, an off-by-one in the data-state count or in the address step shows up immediately. With pseudo-random READY, wait states fall at different halfwords, which exposes any path that advances on a low READY or loses the captured low halfword. Byte accesses at even and odd addresses tell the lane selection apart, and word and burst reads with distinct halfwords catch swapped assembly order. Hold is raised while idle together with a request, and again in the middle of an access, to show that hold is honoured only at the defined points. Two kinds of bad burst confirm that refusal never reaches the bus.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   localparam int HW = 16;

   typedef enum logic [2:0] {
      ST_TI, ST_TH, ST_TA, ST_TS, ST_TW1, ST_TW2, ST_TB1
   } xst_e;

   localparam logic [1:0] SZ_BYTE = 2'b00;
   localparam logic [1:0] SZ_HALF = 2'b01;
   localparam logic [1:0] SZ_WORD = 2'b10;
endpackage

// File: rtl/xbus_ctl.sv
module xbus_ctl import xbus_pkg::*; #(
   parameter int BEATS = 8
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       req_valid,
   input  logic       req_ok,
   input  logic       req_burst,
   input  logic [1:0] req_size,
   input  logic       hold_req,
   input  logic       bus_ready,
   output xst_e       st,
   output logic       launch,
   output logic       cap,
   output logic       cap_hi,
   output logic       cap_solo,
   output logic       adv,
   output logic       done,
   output logic       err
);
   localparam int KW = $clog2(BEATS);

   xst_e          st_q, st_d;
   logic          burst_q, word_q, second_q;
   logic [KW-1:0] beat_q;
   logic          data_st, last_b, fin, reject;

   assign st      = st_q;
   assign data_st = (st_q == ST_TS) || (st_q == ST_TW1) || (st_q == ST_TW2) || (st_q == ST_TB1);
   assign cap     = data_st && bus_ready;
   assign last_b  = (beat_q == KW'(BEATS - 1));
   assign fin     = cap && ((st_q == ST_TS) || (st_q == ST_TW2) || ((st_q == ST_TB1) && last_b));
   assign adv     = cap && !fin;
   assign cap_solo = cap && (st_q == ST_TS);
   assign cap_hi  = cap && ((st_q == ST_TW2) || ((st_q == ST_TB1) && beat_q[0]));
   assign launch  = (st_q == ST_TI) && !hold_req && req_valid && req_ok;
   assign reject  = (st_q == ST_TI) && !hold_req && req_valid && !req_ok;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_TI:  if (hold_req) st_d = ST_TH;
                 else if (launch) st_d = ST_TA;
         ST_TH:  if (!hold_req) st_d = ST_TI;
         ST_TA:  if (second_q) st_d = ST_TW2;
                 else if (burst_q) st_d = ST_TB1;
                 else if (word_q) st_d = ST_TW1;
                 else st_d = ST_TS;
         ST_TW1: if (cap) st_d = ST_TA;
         ST_TS, ST_TW2, ST_TB1:
                 if (fin) st_d = hold_req ? ST_TH : ST_TI;
         default: st_d = ST_TI;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q     <= ST_TI;
         burst_q  <= 1'b0;
         word_q   <= 1'b0;
         second_q <= 1'b0;
         beat_q   <= '0;
         done     <= 1'b0;
         err      <= 1'b0;
      end else begin
         st_q <= st_d;
         done <= fin;
         err  <= reject;
         if (launch) begin
            burst_q  <= req_burst;
            word_q   <= (req_size == SZ_WORD);
            second_q <= 1'b0;
            beat_q   <= '0;
         end
         if ((st_q == ST_TW1) && cap) second_q <= 1'b1;
         if ((st_q == ST_TB1) && adv) beat_q <= beat_q + 1'b1;
      end
   end

   assert_hold_wins_R2: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_TI && hold_req) |=> (st_q == ST_TH));

   assert_word_second_R8: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_TW1 && bus_ready) |=> (st_q == ST_TA));
endmodule

// File: rtl/xbus_dpath.sv
module xbus_dpath import xbus_pkg::*; #(
   parameter int AW        = 32,
   parameter int BEATS     = 8,
   parameter int ALN       = 4,
   parameter bit BYTE_REPL = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                launch,
   input  logic                adv,
   input  xst_e                st,
   input  logic [AW-1:0]       req_addr,
   input  logic [1:0]          req_size,
   input  logic                req_write,
   input  logic                req_io,
   input  logic                req_burst,
   input  logic [BEATS*HW-1:0] req_wdata,
   output logic                req_ok,
   output logic [AW-1:0]       bus_addr,
   output logic [1:0]          bus_be,
   output logic                bus_oe,
   output logic [HW-1:0]       bus_wdata,
   output logic                bus_wr,
   output logic                bus_io,
   output logic                cur_byte,
   output logic                cur_lane,
   output logic                cur_read
);
   localparam int KW = $clog2(BEATS);

   logic [AW-1:0]       r_addr;
   logic [1:0]          r_size;
   logic                r_wr, r_io, r_burst;
   logic [BEATS*HW-1:0] r_wd;
   logic [KW-1:0]       r_k;
   logic [HW-1:0]       byte_word, hw_sel;
   logic                data_st;

   assign req_ok = !(req_burst && (req_io || (req_addr[ALN-1:0] != '0)));

   always_ff @(posedge clk) begin
      if (rst) begin
         r_addr  <= '0;
         r_size  <= SZ_BYTE;
         r_wr    <= 1'b0;
         r_io    <= 1'b0;
         r_burst <= 1'b0;
         r_wd    <= '0;
         r_k     <= '0;
      end else if (launch) begin
         r_addr  <= req_addr;
         r_size  <= req_size;
         r_wr    <= req_write;
         r_io    <= req_io;
         r_burst <= req_burst;
         r_wd    <= req_wdata;
         r_k     <= '0;
      end else if (adv) begin
         r_addr  <= r_addr + AW'(2);
         r_k     <= r_k + 1'b1;
      end
   end

   generate
      if (BYTE_REPL) begin : g_repl
         assign byte_word = {2{r_wd[7:0]}};
      end else begin : g_shift
         assign byte_word = r_addr[0] ? {r_wd[7:0], 8'h00} : {8'h00, r_wd[7:0]};
      end
   endgenerate

   assign cur_byte  = (r_size == SZ_BYTE) && !r_burst;
   assign cur_lane  = r_addr[0];
   assign cur_read  = !r_wr;
   assign hw_sel    = r_wd[r_k*HW +: HW];
   assign data_st   = (st == ST_TS) || (st == ST_TW1) || (st == ST_TW2) || (st == ST_TB1);
   assign bus_addr  = r_addr;
   assign bus_wr    = r_wr;
   assign bus_io    = r_io;
   assign bus_be    = cur_byte ? (r_addr[0] ? 2'b10 : 2'b01) : 2'b11;
   assign bus_wdata = cur_byte ? byte_word : hw_sel;
   assign bus_oe    = r_wr && (data_st || ((st == ST_TA) && !r_burst));

   assert_addr_step_R9: assert property (@(posedge clk) disable iff (rst)
      (adv && !launch) |=> (r_addr == $past(r_addr) + AW'(2)));
endmodule

// File: rtl/xbus_rasm.sv
module xbus_rasm import xbus_pkg::*; (
   input  logic          clk,
   input  logic          rst,
   input  logic          cap,
   input  logic          cap_hi,
   input  logic          cap_solo,
   input  logic          cur_byte,
   input  logic          cur_lane,
   input  logic          cur_read,
   input  logic [HW-1:0] bus_rdata,
   output logic          rd_valid,
   output logic [31:0]   rd_data
);
   logic [HW-1:0] lo_q;
   logic [7:0]    lane_b;

   assign lane_b = cur_lane ? bus_rdata[15:8] : bus_rdata[7:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         lo_q     <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= 1'b0;
         if (cap && !cap_hi && !cap_solo) lo_q <= bus_rdata;
         if (cur_read && cap_solo) begin
            rd_valid <= 1'b1;
            rd_data  <= cur_byte ? {24'h0, lane_b} : {16'h0, bus_rdata};
         end
         if (cur_read && cap_hi) begin
            rd_valid <= 1'b1;
            rd_data  <= {bus_rdata, lo_q};
         end
      end
   end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq import xbus_pkg::*; #(
   parameter int AW          = 32,
   parameter int BURST_WORDS = 4,
   parameter bit BYTE_REPL   = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     req_valid,
   input  logic [AW-1:0]            req_addr,
   input  logic [1:0]               req_size,
   input  logic                     req_write,
   input  logic                     req_io,
   input  logic                     req_burst,
   input  logic [32*BURST_WORDS-1:0] req_wdata,
   output logic                     rd_valid,
   output logic [31:0]              rd_data,
   output logic                     done,
   output logic                     err,
   output logic                     bus_strb,
   output logic                     bus_cs,
   output logic                     bus_io,
   output logic                     bus_wr,
   output logic [AW-1:0]            bus_addr,
   output logic [1:0]               bus_be,
   output logic                     bus_oe,
   output logic [15:0]              bus_wdata,
   input  logic [15:0]              bus_rdata,
   input  logic                     bus_ready,
   input  logic                     hold_req,
   output logic                     hold_ack
);
   localparam int BEATS = BURST_WORDS * 2;
   localparam int ALN   = $clog2(BURST_WORDS * 4);

   generate
      if (BURST_WORDS < 1 || (BURST_WORDS & (BURST_WORDS - 1)) != 0) begin : g_bad_words
         $error("BURST_WORDS must be a power of two");
      end
      if (AW <= ALN) begin : g_bad_aw
         $error("AW too small for burst alignment");
      end
   endgenerate

   xst_e st;
   logic launch, cap, cap_hi, cap_solo, adv, req_ok;
   logic cur_byte, cur_lane, cur_read;

   xbus_ctl #(.BEATS(BEATS)) i_ctl (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ok(req_ok),
      .req_burst(req_burst), .req_size(req_size), .hold_req(hold_req),
      .bus_ready(bus_ready), .st(st), .launch(launch), .cap(cap),
      .cap_hi(cap_hi), .cap_solo(cap_solo), .adv(adv), .done(done), .err(err)
   );

   xbus_dpath #(.AW(AW), .BEATS(BEATS), .ALN(ALN), .BYTE_REPL(BYTE_REPL)) i_dpath (
      .clk(clk), .rst(rst), .launch(launch), .adv(adv), .st(st),
      .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
      .req_io(req_io), .req_burst(req_burst), .req_wdata(req_wdata),
      .req_ok(req_ok), .bus_addr(bus_addr), .bus_be(bus_be), .bus_oe(bus_oe),
      .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_io(bus_io),
      .cur_byte(cur_byte), .cur_lane(cur_lane), .cur_read(cur_read)
   );

   xbus_rasm i_rasm (
      .clk(clk), .rst(rst), .cap(cap), .cap_hi(cap_hi), .cap_solo(cap_solo),
      .cur_byte(cur_byte), .cur_lane(cur_lane), .cur_read(cur_read),
      .bus_rdata(bus_rdata), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   assign bus_strb = (st == ST_TA);
   assign bus_cs   = (st != ST_TI) && (st != ST_TH);
   assign hold_ack = (st == ST_TH);

   assert_strobe_once_R4: assert property (@(posedge clk) disable iff (rst)
      bus_strb |=> !bus_strb);

   assert_wait_stable_R6: assert property (@(posedge clk) disable iff (rst)
      (bus_cs && !bus_strb && !bus_ready) |=> (bus_cs && $stable(bus_addr) && $stable(bus_wdata)));

   assert_done_after_ready_R8: assert property (@(posedge clk) disable iff (rst)
      done |-> $past(bus_ready));

   assert_reject_quiet_R10: assert property (@(posedge clk) disable iff (rst)
      err |-> (!bus_cs && !bus_strb));

   assert_hold_quiet_R2: assert property (@(posedge clk) disable iff (rst)
      hold_ack |-> (!bus_cs && !bus_oe));
endmodule

// File: tb/test_xbus_seq.sv
module test_xbus_seq;
   import xbus_pkg::*;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         req_valid = 1'b0;
   logic [31:0]  req_addr = '0;
   logic [1:0]   req_size = '0;
   logic         req_write = 1'b0, req_io = 1'b0, req_burst = 1'b0;
   logic [127:0] req_wdata = '0;
   logic         rd_valid, done, err, bus_strb, bus_cs, bus_io, bus_wr, bus_oe, hold_ack;
   logic [31:0]  rd_data, bus_addr;
   logic [1:0]   bus_be;
   logic [15:0]  bus_wdata;
   logic [15:0]  bus_rdata = '0;
   logic         bus_ready = 1'b1;
   logic         hold_req = 1'b0;

   always #2 clk = ~clk;

   xbus_seq i_xbus_seq (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
      .req_size(req_size), .req_write(req_write), .req_io(req_io),
      .req_burst(req_burst), .req_wdata(req_wdata), .rd_valid(rd_valid),
      .rd_data(rd_data), .done(done), .err(err), .bus_strb(bus_strb),
      .bus_cs(bus_cs), .bus_io(bus_io), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_be(bus_be), .bus_oe(bus_oe), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ready(bus_ready), .hold_req(hold_req),
      .hold_ack(hold_ack)
   );

   int    checks = 0, fails = 0, cyc = 0;
   string tg = "R1";
   bit    rdy_rand = 1'b0;
   logic [31:0] lfsr = 32'h1ACE_5EED;
   int    n_rv = 0, n_err = 0;

   task automatic chk(input bit ok, input string nm, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tg, nm, act, exp);
      end
   endtask

   // reference model: 0 idle, 1 hold, 2 address, 3 data
   int          mst = 0, m_k = 0, m_tot = 0;
   logic [31:0] m_base = '0;
   logic [1:0]  m_size = '0;
   bit          m_wr = 0, m_io = 0, m_burst = 0;
   logic [127:0] m_wd = '0;
   logic [15:0] m_lo = '0;
   bit          m_done = 0, m_err = 0, m_rv = 0;
   logic [31:0] m_rdat = '0;

   always @(posedge clk) begin
      m_done = 0; m_err = 0; m_rv = 0;
      if (rst) mst = 0;
      else case (mst)
         0: if (hold_req) mst = 1;
            else if (req_valid) begin
               if (req_burst && (req_io || req_addr[3:0] != 4'h0)) m_err = 1;
               else begin
                  m_base = req_addr; m_size = req_size; m_wr = req_write;
                  m_io = req_io; m_burst = req_burst; m_wd = req_wdata; m_k = 0;
                  m_tot = req_burst ? 8 : (req_size == 2'b10 ? 2 : 1);
                  mst = 2;
               end
            end
         1: if (!hold_req) mst = 0;
         2: mst = 3;
         default: if (bus_ready) begin
            if (m_tot == 1) begin
               if (!m_wr) begin
                  m_rv = 1;
                  if (m_size == 2'b00)
                     m_rdat = {24'h0, m_base[0] ? bus_rdata[15:8] : bus_rdata[7:0]};
                  else m_rdat = {16'h0, bus_rdata};
               end
            end else if (m_k % 2 == 0) m_lo = bus_rdata;
            else if (!m_wr) begin m_rv = 1; m_rdat = {bus_rdata, m_lo}; end
            m_k++;
            if (m_k == m_tot) begin m_done = 1; mst = hold_req ? 1 : 0; end
            else if (!m_burst) mst = 2;
         end
      endcase
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (!rst) begin
         logic e_cs, e_oe, e_byte;
         logic [15:0] e_wd;
         logic [31:0] e_addr;
         e_cs   = (mst == 2 || mst == 3);
         e_byte = (m_size == 2'b00) && !m_burst;
         e_addr = m_base + 32'(2 * m_k);
         e_oe   = m_wr && (mst == 3 || (mst == 2 && !m_burst));
         e_wd   = e_byte ? {2{m_wd[7:0]}} : m_wd[m_k*16 +: 16];
         chk(bus_cs == e_cs, "bus_cs", 32'(bus_cs), 32'(e_cs));
         chk(bus_strb == (mst == 2), "bus_strb", 32'(bus_strb), 32'(mst == 2));
         chk(hold_ack == (mst == 1), "hold_ack", 32'(hold_ack), 32'(mst == 1));
         chk(done == m_done, "done", 32'(done), 32'(m_done));
         chk(err == m_err, "err", 32'(err), 32'(m_err));
         chk(rd_valid == m_rv, "rd_valid", 32'(rd_valid), 32'(m_rv));
         chk(bus_oe == e_oe, "bus_oe", 32'(bus_oe), 32'(e_oe));
         if (e_cs) begin
            chk(bus_addr == e_addr, "bus_addr", bus_addr, e_addr);
            chk(bus_wr == m_wr && bus_io == m_io, "bus_wr/io",
                {30'h0, bus_wr, bus_io}, {30'h0, m_wr, m_io});
            chk(bus_be == (e_byte ? (m_base[0] ? 2'b10 : 2'b01) : 2'b11), "bus_be",
                32'(bus_be), 32'(e_byte ? (m_base[0] ? 2'b10 : 2'b01) : 2'b11));
         end
         if (e_oe) chk(bus_wdata == e_wd, "bus_wdata", 32'(bus_wdata), 32'(e_wd));
         if (m_rv) chk(rd_data == m_rdat, "rd_data", rd_data, m_rdat);
         if (rd_valid) n_rv++;
         if (err) n_err++;
      end
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      bus_ready = rdy_rand ? (lfsr[3] | lfsr[7]) : 1'b1;
      bus_rdata = lfsr[23:8];
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 20000) begin
         checks++; fails++;
         $display("FAIL %s watchdog: actual %0d cycles expected fewer", tg, cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic send(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                       input bit io, input bit bst, input logic [127:0] wd);
      req_addr = a; req_size = sz; req_write = wr; req_io = io;
      req_burst = bst; req_wdata = wd; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic settle();
      while (mst == 2 || mst == 3) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic xfer(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                       input bit io, input bit bst, input logic [127:0] wd);
      send(a, sz, wr, io, bst, wd);
      settle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      tg = "R1";
      repeat (4) @(negedge clk);

      tg = "R4";
      xfer(32'h0000_0100, 2'b01, 0, 0, 0, '0);
      xfer(32'h0000_0112, 2'b01, 1, 1, 0, 128'h5A3C);

      tg = "R7";
      xfer(32'h0000_0203, 2'b00, 0, 0, 0, '0);
      xfer(32'h0000_0204, 2'b00, 0, 1, 0, '0);
      xfer(32'h0000_0305, 2'b00, 1, 0, 0, 128'hA5);
      xfer(32'h0000_0306, 2'b01, 1, 0, 0, 128'hBEEF);

      tg = "R8";
      xfer(32'h0000_0400, 2'b10, 0, 0, 0, '0);
      xfer(32'h0000_0408, 2'b10, 0, 1, 0, '0);

      tg = "R6";
      rdy_rand = 1'b1;
      for (int i = 0; i < 6; i++) begin
         xfer(32'h0000_0410 + 32'(4 * i), 2'b10, 0, 0, 0, '0);
         xfer(32'h0000_0441 + 32'(2 * i), 2'b00, 0, 0, 0, '0);
      end

      tg = "R5";
      xfer(32'h0000_0500, 2'b10, 1, 0, 0, 128'hDEAD_BEEF);
      xfer(32'h0000_0600, 2'b10, 1, 0, 1, 128'h0F0E_0D0C_0B0A_0908_0706_0504_0302_0100);
      rdy_rand = 1'b0;
      xfer(32'h0000_0610, 2'b10, 1, 0, 1, 128'h1111_2222_3333_4444_5555_6666_7777_8888);

      tg = "R9";
      n_rv = 0;
      xfer(32'h0000_0700, 2'b10, 0, 0, 1, '0);
      chk(n_rv == 4, "word count", 32'(n_rv), 32'd4);
      rdy_rand = 1'b1;
      n_rv = 0;
      xfer(32'h0000_0740, 2'b10, 0, 0, 1, '0);
      chk(n_rv == 4, "word count", 32'(n_rv), 32'd4);
      rdy_rand = 1'b0;

      tg = "R10";
      n_err = 0;
      xfer(32'h0000_0800, 2'b10, 0, 1, 1, '0);
      xfer(32'h0000_0808, 2'b10, 1, 0, 1, '0);
      xfer(32'h0000_0802, 2'b10, 0, 0, 1, '0);
      chk(n_err == 3, "refusals", 32'(n_err), 32'd3);

      tg = "R2";
      hold_req = 1'b1;
      send(32'h0000_0900, 2'b01, 0, 0, 0, '0);
      repeat (5) @(negedge clk);
      chk(hold_ack == 1'b1, "hold_ack held", 32'(hold_ack), 32'd1);
      hold_req = 1'b0;
      repeat (2) @(negedge clk);
      xfer(32'h0000_0904, 2'b01, 0, 0, 0, '0);

      tg = "R3";
      rdy_rand = 1'b1;
      send(32'h0000_0A00, 2'b10, 0, 0, 1, '0);
      @(negedge clk);
      hold_req = 1'b1;
      while (mst == 2 || mst == 3) @(negedge clk);
      chk(hold_ack == 1'b1, "hold after access", 32'(hold_ack), 32'd1);
      repeat (3) @(negedge clk);
      hold_req = 1'b0;
      repeat (2) @(negedge clk);
      send(32'h0000_0B00, 2'b10, 1, 0, 0, 128'h1234_5678);
      hold_req = 1'b1;
      while (mst == 2 || mst == 3) @(negedge clk);
      repeat (2) @(negedge clk);
      hold_req = 1'b0;
      rdy_rand = 1'b0;
      repeat (3) @(negedge clk);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule